// File: doc/BRIEF.md
# Condition-Field to Integer Bit Packer

This unit turns a vector of 4-bit condition fields into a packed predicate mask held in integer registers. After a start strobe it walks element indices 0 through VL-1, one per clock. For each element it reads condition field i and picks one of its four bits with a 2-bit select. It can optionally invert that bit. It then merges the result into one bit of a destination integer register. The first destination register is RT.

A 2-bit element-width code sets the packing density. Code 00 puts one result per register, 01 puts two, 10 puts four and 11 puts eight. Elements fill each register upward from its least significant bit. Under MSB0 numbering, element k of a register lands at index 63-k.

Each merge is a read-modify-write of a single bit, so all other bits of the destination keep their old contents. When consecutive elements share a destination, the pending write is forwarded to the next read. The unit drives a combinational read port on the condition-field array. It also drives a combinational read port and a registered write port on a 32-entry, 64-bit register file. It reports progress with busy and done.

Top module: `cr_bit_packer`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done and rfWrEn are low.
- R2: The result bit of element i is crData[3-sel] of field i, XORed with invIn. The select encoding is sel 0 = LT on crData[3], 1 = GT on crData[2], 2 = EQ on crData[1] and 3 = SO on crData[0].
- R3: With ewIn = 00, element i writes only bit 0 (MSB0 index 63) of register RT+i.
- R4: With ewIn = 01, 10 or 11, element i writes register RT+(i>>ewIn) at LSB-relative bit i mod 2^ewIn, which is MSB0 index 63-(i mod 2^ewIn). Register numbers wrap modulo 32.
- R5: Bits and registers that no element targets keep their previous values.
- R6: Successive elements that target the same register all accumulate in it, including elements that are written in back-to-back cycles.
- R7: A run of VL > 0 elements keeps busy high for exactly VL+1 cycles. It makes exactly VL writes, at one per cycle after the first. done pulses for a single cycle right after the last write, with busy low.
- R8: A start with VL = 0 raises done in the next cycle. busy stays low and no register is written.
- R9: A start that arrives while busy is ignored and does not change the run in progress.
- R10: A VL above 64 is processed as VL = 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| vlIn | input | 7 | Vector length, 0 to 64 (larger values clamp) |
| rtIn | input | 5 | First destination register |
| ewIn | input | 2 | Packing density code |
| selIn | input | 2 | Condition bit select |
| invIn | input | 1 | Invert the selected bit |
| crAddr | output | 6 | Condition field index being read |
| crData | input | 4 | Condition field read data, same cycle |
| rfRdAddr | output | 5 | Register file read address |
| rfRdData | input | 64 | Register file read data, same cycle |
| rfWrEn | output | 1 | Register file write enable |
| rfWrAddr | output | 5 | Register file write address |
| rfWrData | output | 64 | Register file write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take two things for granted. The first is that a busy period only ever starts from an idle cycle. The second is that start is a plain level, sampled on every clock, which may stay high or be repeated. They also rely on the register file committing rfWrData at the clock edge that ends a write cycle, so that only the forwarded path can carry a merge that has just happened. The bench models the register file with exactly that behaviour and returns reads combinationally in the same cycle. It raises start only when a new run is wanted, except for one deliberate pulse in the middle of a run. Field contents, register contents and run parameters are drawn at random within the legal ranges. Directed cases cover VL of 0, 64 and above 64, register wrap and every select value.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  typedef enum logic [1:0] {
    EW_ONE   = 2'd0,
    EW_TWO   = 2'd1,
    EW_FOUR  = 2'd2,
    EW_EIGHT = 2'd3
  } ewCode_t;

  typedef struct packed {
    logic load;
    logic issue;
  } cbpStrobe_t;

  function automatic logic pickBit(input logic [3:0] field, input logic [1:0] sel,
                                   input logic inv);
    return field[2'd3 - sel] ^ inv;
  endfunction

endpackage

// File: rtl/cbp_ctrl.sv
module cbp_ctrl
  import cbp_pkg::*;
#(
  parameter int VL_MAX = 64,
  localparam int VLW = $clog2(VL_MAX + 1),
  localparam int IDXW = $clog2(VL_MAX)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [VLW-1:0]  vlIn,
  output cbpStrobe_t      strb,
  output logic [IDXW-1:0] idx,
  output logic            busy,
  output logic            done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} state_t;

  state_t          state;
  logic [IDXW-1:0] lastIdx;
  logic [VLW-1:0]  vlEff;
  logic            doneQ;

  assign vlEff = (vlIn > VLW'(VL_MAX)) ? VLW'(VL_MAX) : vlIn;

  always_comb begin
    strb.load  = (state == ST_IDLE) && start && (vlEff != '0);
    strb.issue = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      lastIdx <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (vlEff == '0) begin
              doneQ <= 1'b1;
            end else begin
              state   <= ST_RUN;
              idx     <= '0;
              lastIdx <= IDXW'(vlEff - VLW'(1));
            end
          end
        end
        ST_RUN: begin
          if (idx == lastIdx) state <= ST_DRAIN;
          else                idx   <= idx + IDXW'(1);
        end
        ST_DRAIN: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/cbp_datapath.sv
module cbp_datapath
  import cbp_pkg::*;
#(
  parameter int VL_MAX = 64,
  parameter int REG_COUNT = 32,
  parameter int XLEN = 64,
  localparam int IDXW = $clog2(VL_MAX),
  localparam int RAW = $clog2(REG_COUNT),
  localparam int LANEW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  cbpStrobe_t      strb,
  input  logic [IDXW-1:0] idx,
  input  logic [RAW-1:0]  rtIn,
  input  logic [1:0]      ewIn,
  input  logic [1:0]      selIn,
  input  logic            invIn,
  output logic [IDXW-1:0] crAddr,
  input  logic [3:0]      crData,
  output logic [RAW-1:0]  rfRdAddr,
  input  logic [XLEN-1:0] rfRdData,
  output logic            rfWrEn,
  output logic [RAW-1:0]  rfWrAddr,
  output logic [XLEN-1:0] rfWrData
);

  logic [RAW-1:0]   rtQ;
  ewCode_t          ewQ;
  logic [1:0]       selQ;
  logic             invQ;

  logic [LANEW-1:0] laneMask;
  logic [LANEW-1:0] bitPos;
  logic [IDXW-1:0]  regOff;
  logic [RAW-1:0]   rdAddr;
  logic             resBit;
  logic             fwd;
  logic [XLEN-1:0]  baseWord;
  logic [XLEN-1:0]  merged;

  logic             wrValid;
  logic [RAW-1:0]   wrAddr;
  logic [XLEN-1:0]  wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtQ  <= '0;
      ewQ  <= EW_ONE;
      selQ <= '0;
      invQ <= 1'b0;
    end else if (strb.load) begin
      rtQ  <= rtIn;
      ewQ  <= ewCode_t'(ewIn);
      selQ <= selIn;
      invQ <= invIn;
    end
  end

  always_comb begin
    laneMask = LANEW'((4'd1 << ewQ) - 4'd1);
    bitPos   = idx[LANEW-1:0] & laneMask;
    regOff   = idx >> ewQ;
    rdAddr   = rtQ + RAW'(regOff);
    resBit   = pickBit(crData, selQ, invQ);
    fwd      = wrValid && (wrAddr == rdAddr);
    baseWord = fwd ? wrData : rfRdData;
  end

  for (genvar b = 0; b < XLEN; b++) begin : g_merge
    if (b < (1 << LANEW)) begin : g_lane
      assign merged[b] = (bitPos == LANEW'(b)) ? resBit : baseWord[b];
    end else begin : g_keep
      assign merged[b] = baseWord[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrValid <= strb.issue;
      if (strb.issue) begin
        wrAddr <= rdAddr;
        wrData <= merged;
      end
    end
  end

  assign crAddr   = idx;
  assign rfRdAddr = rdAddr;
  assign rfWrEn   = wrValid;
  assign rfWrAddr = wrAddr;
  assign rfWrData = wrData;

endmodule

// File: rtl/cr_bit_packer.sv
module cr_bit_packer
  import cbp_pkg::*;
#(
  parameter int VL_MAX = 64,
  parameter int REG_COUNT = 32,
  parameter int XLEN = 64,
  localparam int VLW = $clog2(VL_MAX + 1),
  localparam int IDXW = $clog2(VL_MAX),
  localparam int RAW = $clog2(REG_COUNT)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [VLW-1:0]  vlIn,
  input  logic [RAW-1:0]  rtIn,
  input  logic [1:0]      ewIn,
  input  logic [1:0]      selIn,
  input  logic            invIn,
  output logic [IDXW-1:0] crAddr,
  input  logic [3:0]      crData,
  output logic [RAW-1:0]  rfRdAddr,
  input  logic [XLEN-1:0] rfRdData,
  output logic            rfWrEn,
  output logic [RAW-1:0]  rfWrAddr,
  output logic [XLEN-1:0] rfWrData,
  output logic            busy,
  output logic            done
);

  cbpStrobe_t      strb;
  logic [IDXW-1:0] idx;

  cbp_ctrl #(.VL_MAX(VL_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vlIn(vlIn),
    .strb(strb), .idx(idx), .busy(busy), .done(done)
  );

  cbp_datapath #(.VL_MAX(VL_MAX), .REG_COUNT(REG_COUNT), .XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx),
    .rtIn(rtIn), .ewIn(ewIn), .selIn(selIn), .invIn(invIn),
    .crAddr(crAddr), .crData(crData),
    .rfRdAddr(rfRdAddr), .rfRdData(rfRdData),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData)
  );

endmodule

// File: rtl/cbp_checker.sv
module cbp_checker #(
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic [VLW-1:0] vlIn,
  input logic           rfWrEn,
  input logic           busy,
  input logic           done
);

  AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> busy); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done); // R7

  AST_WR_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(rfWrEn)) |-> rfWrEn); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rfWrEn) |=> busy); // R9

  AST_ZERO_VL: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (vlIn == '0)) |=> (done && !busy && !rfWrEn)); // R8

endmodule

bind cr_bit_packer cbp_checker #(.VLW(VLW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .vlIn(vlIn),
  .rfWrEn(rfWrEn), .busy(busy), .done(done)
);

// File: tb/cr_bit_packer_tb.sv
`timescale 1ns/1ps
module cr_bit_packer_tb;

  localparam int NREG = 32;
  localparam int NCR = 64;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [6:0]  vlIn;
  logic [4:0]  rtIn;
  logic [1:0]  ewIn;
  logic [1:0]  selIn;
  logic        invIn;
  logic [5:0]  crAddr;
  logic [3:0]  crData;
  logic [4:0]  rfRdAddr;
  logic [63:0] rfRdData;
  logic        rfWrEn;
  logic [4:0]  rfWrAddr;
  logic [63:0] rfWrData;
  logic        busy;
  logic        done;

  logic [63:0] rf [NREG];
  logic [63:0] presetRf [NREG];
  logic        presetReq;
  logic [3:0]  cr [NCR];
  int          wrCount;
  int          checks;
  int          errors;

  always #4 clk = ~clk;

  cr_bit_packer u_dut (
    .clk(clk), .rstN(rstN), .start(start), .vlIn(vlIn), .rtIn(rtIn),
    .ewIn(ewIn), .selIn(selIn), .invIn(invIn), .crAddr(crAddr), .crData(crData),
    .rfRdAddr(rfRdAddr), .rfRdData(rfRdData), .rfWrEn(rfWrEn),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData), .busy(busy), .done(done)
  );

  assign crData   = cr[crAddr];
  assign rfRdData = rf[rfRdAddr];

  always @(posedge clk) begin
    if (presetReq) begin
      for (int r = 0; r < NREG; r++) rf[r] <= presetRf[r];
    end else if (rfWrEn) begin
      rf[rfWrAddr] <= rfWrData;
      wrCount <= wrCount + 1;
    end
  end

  initial begin
    #1_000_000;
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run did not finish, actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic resBit(input int i, input int sel, input bit inv);
    return cr[i][3-sel] ^ inv;
  endfunction

  task automatic fillRandom(input bit allOnes, input bit allZero);
    for (int i = 0; i < NCR; i++) cr[i] = 4'($urandom);
    for (int r = 0; r < NREG; r++)
      presetRf[r] = allOnes ? '1 : allZero ? '0 : {$urandom, $urandom};
    @(negedge clk); presetReq = 1'b1;
    @(negedge clk); presetReq = 1'b0;
  endtask

  task automatic runOp(input int vl, input int rt, input int ew, input int sel,
                       input bit inv, input bit poke, input string req);
    logic [63:0] expRf [NREG];
    int vEff, w0, busyCyc, guard, bad, badReg;
    vEff = (vl > 64) ? 64 : vl;
    for (int r = 0; r < NREG; r++) expRf[r] = rf[r];
    for (int i = 0; i < vEff; i++) begin
      int r, k;
      r = (rt + (i >> ew)) % NREG;
      k = i % (1 << ew);
      expRf[r][k] = resBit(i, sel, inv);
    end
    w0 = wrCount;
    @(negedge clk);
    start = 1'b1; vlIn = 7'(vl); rtIn = 5'(rt); ewIn = 2'(ew);
    selIn = 2'(sel); invIn = inv;
    @(negedge clk);
    start = 1'b0;
    busyCyc = 0; guard = 0;
    if (vl == 0) check(done == 1'b1 && busy == 1'b0, "R8", "done in next cycle", done, 1);
    while (!done && guard < 200) begin
      if (busy) busyCyc++;
      if (poke && busyCyc == 2) begin
        start = 1'b1; vlIn = 7'd3; rtIn = 5'(rt + 1); ewIn = 2'd0;
        selIn = 2'(sel); invIn = ~inv;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    check(done == 1'b1, req, "done seen", done, 1);
    check(busy == 1'b0, "R7", "busy low with done", busy, 0);
    check(busyCyc == ((vEff == 0) ? 0 : vEff + 1), (vEff == 0) ? "R8" : "R7",
          "busy cycles", busyCyc, (vEff == 0) ? 0 : vEff + 1);
    check((wrCount - w0) == vEff, (vEff == 0) ? "R8" : "R7", "write count",
          wrCount - w0, vEff);
    bad = 0; badReg = 0;
    for (int r = 0; r < NREG; r++)
      if (rf[r] !== expRf[r] && bad == 0) begin bad = 1; badReg = r; end
    check(bad == 0, req, $sformatf("register %0d contents", badReg), rf[badReg],
          expRf[badReg]);
    @(negedge clk);
    check(done == 1'b0, "R7", "done one cycle", done, 0);
  endtask

  initial begin
    checks = 0; errors = 0; wrCount = 0;
    rstN = 1'b0; start = 1'b0; vlIn = '0; rtIn = '0; ewIn = '0; selIn = '0;
    invIn = 1'b0; presetReq = 1'b0;
    void'($urandom(32'd20240611));
    for (int r = 0; r < NREG; r++) presetRf[r] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !rfWrEn, "R1", "outputs in reset",
          {busy, done, rfWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rfWrEn, "R1", "outputs after reset",
          {busy, done, rfWrEn}, 0);

    fillRandom(0, 0); runOp(8, 2, 0, 0, 0, 0, "R3");
    fillRandom(0, 0); runOp(5, 7, 1, 2, 0, 0, "R4");
    fillRandom(0, 0); runOp(16, 30, 2, 1, 0, 0, "R4");
    fillRandom(0, 0); runOp(64, 28, 3, 3, 1, 0, "R6");
    fillRandom(0, 0); runOp(9, 0, 3, 1, 1, 0, "R2");
    fillRandom(0, 0); runOp(6, 11, 1, 3, 0, 0, "R2");
    fillRandom(1, 0); runOp(3, 4, 3, 0, 1, 0, "R5");
    fillRandom(0, 1); runOp(12, 20, 2, 2, 1, 0, "R5");
    fillRandom(0, 0); runOp(0, 5, 0, 0, 0, 0, "R8");
    fillRandom(0, 0); runOp(100, 3, 3, 0, 0, 0, "R10");
    fillRandom(0, 0); runOp(10, 9, 0, 1, 0, 1, "R9");
    for (int n = 0; n < 20; n++) begin
      fillRandom(0, 0);
      runOp(int'($urandom_range(0, 64)), int'($urandom_range(0, 31)),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            1'($urandom), 0, "R5");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule